// File: doc/BRIEF.md
# Burst Low-Address Generator

This block produces the three low-order address bits that a memory controller drives to a memory device during a burst. When an on-chip master owns the transfer, the output simply follows the low address bits of the bus. When an external master starts a transfer, the block first shows the bus bits in the opening cycle. It then keeps its own copy of those bits and changes that copy only when a programmable timing sequencer asks for an increment. This lets a burst from an outside master walk through consecutive memory locations even though that master drives only the starting address.

A transfer begins with a one-cycle start pulse. The master-origin flag is sampled together with that pulse. An end pulse closes an external transfer, and from the following cycle the output passes the bus bits through again. The sequencer and the address decoding are outside this block.

Top module: `burst_lowaddr_gen`

## Requirements
- R1: After synchronous reset (rst_n low at a rising edge), the block is in pass-through mode: with no start pulse, burst_addr equals bus_lo. This holds even if reset arrives in the middle of an external transfer.
- R2: While no external transfer is held, burst_addr equals bus_lo in every cycle, and step_en has no effect.
- R3: In any cycle where xfer_start is 1, burst_addr equals bus_lo in that same cycle, whatever ext_master is.
- R4: From the cycle after a start with ext_master = 1, burst_addr shows the bus_lo value captured at that start. It ignores later changes on bus_lo until a step, an end or a new start.
- R5: Each rising edge with step_en = 1, no xfer_start and an external transfer held raises burst_addr by exactly one from the next cycle onward. There is at most one increment per clock.
- R6: The increment wraps modulo 8: a held value of 7 becomes 0.
- R7: step_en sampled at the same edge as xfer_start has no effect. The captured value is the bus_lo value itself, not that value plus one.
- R8: xfer_end = 1 at a rising edge, without xfer_start, returns the block to pass-through from the next cycle. If xfer_start and xfer_end are both 1 at the same edge, the start wins and the new transfer begins.
- R9: A new xfer_start reloads the held value from bus_lo and re-samples ext_master, even while an external transfer is still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_lo | input | 3 | Low-order address bits from the bus |
| xfer_start | input | 1 | One-cycle pulse on the first cycle of a memory access |
| ext_master | input | 1 | 1 when the starting transfer comes from an external master; sampled with xfer_start |
| step_en | input | 1 | Increment command from the timing sequencer, one per clock at most |
| xfer_end | input | 1 | Marks the last cycle of a transfer |
| burst_addr | output | 3 | Burst low address to the memory device |

## Verification
The assertions take for granted that xfer_start is a single-cycle pulse and that ext_master is only meaningful together with it. They also assume that step_en and xfer_end may arrive in any cycle, including at the same edge as a start. The hold and step properties therefore allow a new start in the next cycle, because that start replaces the held value with the bus bits. The stimulus always drives every input at the falling edge and keeps the start to one cycle. It then deliberately lines up step and end commands with starts, so that the priority rules are exercised within those assumptions.

// File: rtl/burst_addr_pkg.sv
// Package: shared types for the burst low-address generator.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package burst_addr_pkg;

    // Width of the burst low-address field used by default.
    localparam int BURST_AW_DEFAULT = 3;

    // Source currently selected for the burst address outside the start cycle.
    typedef enum logic {
        SRC_BUS  = 1'b0,   // follow the bus low bits
        SRC_HELD = 1'b1    // show the captured, stepping copy
    } addr_src_e;

endpackage

// File: rtl/master_mode_tracker.sv
// Module: master_mode_tracker
// Keeps track of whether an external-master transfer is currently held.
// The master origin is sampled only on the start pulse. An end pulse without
// a start returns to bus pass-through. Start has priority over end.
// Assumes: xfer_start is a single-cycle pulse.
module master_mode_tracker
    import burst_addr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      xfer_start,
    input  logic      ext_master,
    input  logic      xfer_end,
    output addr_src_e src_mode
);

    addr_src_e mode_q;

    // Purpose: capture master origin on start, fall back to bus on end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= SRC_BUS;
        end else if (xfer_start) begin
            mode_q <= ext_master ? SRC_HELD : SRC_BUS;
        end else if (xfer_end) begin
            mode_q <= SRC_BUS;
        end
    end

    assign src_mode = mode_q;

endmodule

// File: rtl/burst_addr_counter.sv
// Module: burst_addr_counter
// Holds the captured low address and steps it modulo 2**AW on command.
// A start always reloads from the bus and overrides any step command.
// Assumes: step_ok is already qualified by the caller (external transfer held).
module burst_addr_counter #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer_start,
    input  logic [AW-1:0] bus_lo,
    input  logic          step_ok,
    output logic [AW-1:0] held_addr
);

    localparam logic [AW-1:0] STEP_ONE = AW'(1);

    logic [AW-1:0] held_q;
    logic [AW-1:0] held_d;

    // Purpose: choose reload, increment or hold for the captured address.
    always_comb begin
        if (xfer_start) begin
            held_d = bus_lo;
        end else if (step_ok) begin
            held_d = held_q + STEP_ONE;
        end else begin
            held_d = held_q;
        end
    end

    // Purpose: register the captured address, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else begin
            held_q <= held_d;
        end
    end

    assign held_addr = held_q;

endmodule

// File: rtl/burst_addr_select.sv
// Module: burst_addr_select
// Bitwise output selector: in the start cycle, or while in pass-through mode,
// the bus bits reach the output; otherwise the held copy does.
// Assumes: use_bus is settled within the cycle (purely combinational path).
module burst_addr_select #(
    parameter int AW = 3
) (
    input  logic          use_bus,
    input  logic [AW-1:0] bus_lo,
    input  logic [AW-1:0] held_addr,
    output logic [AW-1:0] addr_out
);

    // One 2:1 selector per address bit.
    for (genvar b = 0; b < AW; b++) begin : g_bit
        assign addr_out[b] = use_bus ? bus_lo[b] : held_addr[b];
    end

endmodule

// File: rtl/burst_lowaddr_gen.sv
// Module: burst_lowaddr_gen (top)
// Generates the burst low address. It passes the bus bits through for
// on-chip masters. For external masters it captures the bits in the first
// cycle and steps them on sequencer command.
// Assumes: xfer_start is a one-cycle pulse; ext_master is valid with it.
module burst_lowaddr_gen
    import burst_addr_pkg::*;
#(
    parameter int AW = BURST_AW_DEFAULT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_lo,
    input  logic          xfer_start,
    input  logic          ext_master,
    input  logic          step_en,
    input  logic          xfer_end,
    output logic [AW-1:0] burst_addr
);

    addr_src_e     src_mode;
    logic          ext_hold;
    logic          step_ok;
    logic          use_bus;
    logic [AW-1:0] held_addr;

    u_mode_unused_guard: assert final (AW > 0);

    master_mode_tracker u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_start (xfer_start),
        .ext_master (ext_master),
        .xfer_end   (xfer_end),
        .src_mode   (src_mode)
    );

    // Purpose: derive control strobes from the tracked mode.
    always_comb begin
        ext_hold = (src_mode == SRC_HELD);
        step_ok  = step_en && ext_hold && !xfer_start;
        use_bus  = xfer_start || !ext_hold;
    end

    burst_addr_counter #(.AW(AW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_start (xfer_start),
        .bus_lo     (bus_lo),
        .step_ok    (step_ok),
        .held_addr  (held_addr)
    );

    burst_addr_select #(.AW(AW)) u_sel (
        .use_bus    (use_bus),
        .bus_lo     (bus_lo),
        .held_addr  (held_addr),
        .addr_out   (burst_addr)
    );

endmodule

// File: rtl/burst_lowaddr_gen_chk.sv
// Module: burst_lowaddr_gen_chk
// Checker bound to burst_lowaddr_gen; observes ports and the tracked mode.
// Assumes: reset is asserted at the first clock edge.
module burst_lowaddr_gen_chk #(
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_lo,
    input logic          xfer_start,
    input logic          ext_master,
    input logic          step_en,
    input logic          xfer_end,
    input logic [AW-1:0] burst_addr,
    input logic          ext_hold
);

    assert_start_shows_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> (burst_addr == bus_lo));

    assert_internal_no_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && !ext_master) |=> !ext_hold);

    assert_capture_on_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && ext_master) |=> (ext_hold && (xfer_start || burst_addr == $past(bus_lo))));

    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_hold && !xfer_start && !xfer_end && !step_en) |=> (xfer_start || $stable(burst_addr)));

    assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_hold && !xfer_start && !xfer_end && step_en)
        |=> (xfer_start || burst_addr == AW'($past(burst_addr) + AW'(1))));

    assert_end_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_end && !xfer_start) |=> !ext_hold);

    assert_reset_releases_R1: assert property (@(posedge clk)
        !rst_n |=> !ext_hold);

endmodule

bind burst_lowaddr_gen burst_lowaddr_gen_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_lo     (bus_lo),
    .xfer_start (xfer_start),
    .ext_master (ext_master),
    .step_en    (step_en),
    .xfer_end   (xfer_end),
    .burst_addr (burst_addr),
    .ext_hold   (ext_hold)
);

// File: tb/burst_lowaddr_gen_test.sv
// Bench: scoreboard. The driver pushes expected outputs computed from the
// requirements; the monitor pops and compares them a quarter period after
// each falling edge.
module burst_lowaddr_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 3;
    localparam int WATCHDOG_CYCLES = 5000;

    typedef struct {
        logic [AW-1:0] val;
        string         tag;
    } exp_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_lo = '0;
    logic          xfer_start = 1'b0;
    logic          ext_master = 1'b0;
    logic          step_en = 1'b0;
    logic          xfer_end = 1'b0;
    logic [AW-1:0] burst_addr;

    exp_item_t exp_q[$];
    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Bench-side reference state, built from the requirements.
    logic          m_hold = 1'b0;
    logic [AW-1:0] m_latch = '0;

    burst_lowaddr_gen #(.AW(AW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_lo     (bus_lo),
        .xfer_start (xfer_start),
        .ext_master (ext_master),
        .step_en    (step_en),
        .xfer_end   (xfer_end),
        .burst_addr (burst_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: one call is one clock cycle of stimulus plus its expected output.
    task automatic drive(input logic [AW-1:0] b, input logic st, input logic ex,
                         input logic sp, input logic en, input string tag);
        exp_item_t it;
        @(negedge clk);
        bus_lo = b; xfer_start = st; ext_master = ex; step_en = sp; xfer_end = en;
        it.val = (st || !m_hold) ? b : m_latch;
        it.tag = tag;
        exp_q.push_back(it);
        if (st) begin
            m_hold = ex;
            m_latch = b;
        end else begin
            if (m_hold && sp) m_latch = m_latch + 3'd1;
            if (en) m_hold = 1'b0;
        end
    endtask

    task automatic apply_reset(input int n);
        @(negedge clk);
        rst_n = 1'b0; xfer_start = 1'b0; step_en = 1'b0; xfer_end = 1'b0;
        repeat (n) @(negedge clk);
        rst_n = 1'b1;
        m_hold = 1'b0;
        m_latch = '0;
    endtask

    // Monitor: compare the output against the queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                exp_item_t it;
                it = exp_q.pop_front();
                vectors++;
                if (burst_addr !== it.val) begin
                    miscompares++;
                    $display("FAIL %s: burst_addr=%0d expected %0d", it.tag, burst_addr, it.val);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        while (!done && cycles < WATCHDOG_CYCLES) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG_CYCLES);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        apply_reset(2);
        // R1: reset leaves pass-through
        drive(3'd5, 0, 0, 0, 0, "R1 reset pass-through");
        drive(3'd2, 0, 0, 1, 0, "R1 R2 idle step ignored");
        // Internal transfer: R3 then R2
        drive(3'd3, 1, 0, 0, 0, "R3 internal start");
        drive(3'd6, 0, 0, 1, 0, "R2 internal follows bus");
        drive(3'd1, 0, 0, 1, 0, "R2 internal step ignored");
        drive(3'd4, 0, 0, 0, 1, "R2 internal end");
        // External transfer, step at start ignored (R7)
        drive(3'd2, 1, 1, 1, 0, "R3 external start");
        drive(3'd7, 0, 0, 0, 0, "R7 step at start ignored");
        drive(3'd0, 0, 0, 1, 0, "R4 holds despite bus");
        drive(3'd5, 0, 0, 1, 0, "R5 stepped once");
        drive(3'd5, 0, 0, 0, 0, "R5 stepped twice");
        drive(3'd1, 0, 0, 0, 0, "R4 hold without step");
        // Wrap: start at 6, step three times
        drive(3'd6, 1, 1, 0, 0, "R3 R9 reload at 6");
        drive(3'd0, 0, 0, 1, 0, "R9 reloaded value");
        drive(3'd0, 0, 0, 1, 0, "R6 step to 7");
        drive(3'd0, 0, 0, 1, 0, "R6 wrap to 0");
        drive(3'd3, 0, 0, 0, 1, "R6 wrapped value, end");
        drive(3'd3, 0, 0, 0, 0, "R8 pass-through after end");
        // Start and end together: start wins
        drive(3'd4, 1, 1, 0, 1, "R8 start with end");
        drive(3'd2, 0, 0, 0, 0, "R8 start wins held");
        // Back-to-back starts reload
        drive(3'd1, 1, 1, 0, 0, "R9 new start");
        drive(3'd7, 0, 0, 0, 0, "R9 held 1");
        drive(3'd6, 1, 0, 0, 0, "R9 internal restart");
        drive(3'd2, 0, 0, 1, 0, "R9 internal after restart");
        // Reset in the middle of an external transfer
        drive(3'd3, 1, 1, 0, 0, "R3 external before reset");
        drive(3'd5, 0, 0, 0, 0, "R4 held before reset");
        apply_reset(1);
        drive(3'd6, 0, 0, 1, 0, "R1 reset mid-transfer");
        drive(3'd6, 0, 0, 0, 0, "R1 stays pass-through");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule